// File: doc/BRIEF.md
# Branch and Next-PC Resolution Unit

This unit decides where a 32-bit RISC core fetches next. Each cycle it takes the current program counter, a decoded transfer kind, two register operands, a 16-bit signed branch displacement, a 26-bit jump field and an optional link destination. From these it produces the next program counter, a taken flag, and a link write (enable, register index, value) for call instructions.

Conditional transfers come in two groups. Two-register branches test only equality or inequality. Single-register branches compare one signed operand with zero, and the compare code travels in the second register field of the instruction. A branch displacement counts instructions, not bytes, and is measured from the instruction that follows the branch. Direct jumps stay inside the 256 MB region of the following instruction. Register-indirect jumps go to the operand value. Direct calls link into register 31. Indirect calls link into the named register, or into register 31 when that field is zero.

All results are computed combinationally and then held in one output register, so a decision appears one clock after its inputs. The block has no state machine. The output register is its only state, and it comes out of reset holding the reset vector with taken and link-write low.

Top module: `bru_nextpc`

## Requirements
- R1: While `rst_n` is low, `next_pc` equals the parameter RESET_PC (default 32'hBFC0_0000), and `taken` and `link_we` are 0.
- R2: Kind 0 (sequential) gives `next_pc` = `cur_pc` + 4 with `taken` = 0.
- R3: Kind 1 (branch if equal) is taken exactly when `opnd_a` == `opnd_b`. Kind 2 (branch if not equal) is taken exactly when they differ. A taken branch gives `next_pc` = `cur_pc` + 4 + (sign-extended `br_off` << 2). A branch that is not taken gives `cur_pc` + 4.
- R4: Kind 3 compares the signed `opnd_a` with zero using `zcond`. Code 0 means less than zero, 1 means greater than or equal, 2 means less than or equal, and 3 means greater than zero. The target is the same as in R3.
- R5: Kind 3 with any `zcond` value above 3 is never taken and gives `cur_pc` + 4.
- R6: The displacement spans its full signed range: +32767 and -32768 instructions reach ±128 KB around `cur_pc` + 4, with 32-bit wraparound.
- R7: An equality branch with both operands zero, which is the zero register compared with itself, is always taken.
- R8: Kind 4 (direct jump) gives `next_pc` = {(`cur_pc`+4)[31:28], `jmp_field`, 2'b00} with `taken` = 1.
- R9: Kind 6 (indirect jump) gives `next_pc` = `opnd_a` with `taken` = 1.
- R10: Kind 5 (direct call) jumps as in R8 and raises `link_we` with `link_idx` = 31 and `link_val` = `cur_pc` + 4.
- R11: Kind 7 (indirect call) jumps as in R9 and raises `link_we` with `link_val` = `cur_pc` + 4. `link_idx` equals `link_dst`, or 31 when `link_dst` is 0.
- R12: Kinds 0, 1, 2, 3, 4 and 6 keep `link_we` at 0.
- R13: Outputs change only at a rising clock edge and show the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address of the current instruction |
| xfer_kind | input | 3 | Transfer kind code (see R2 to R11) |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| zcond | input | 5 | Compare code for sign tests against zero |
| br_off | input | 16 | Signed branch displacement in instructions |
| jmp_field | input | 26 | Direct jump target field |
| link_dst | input | 5 | Destination for indirect call link, 0 selects 31 |
| next_pc | output | 32 | Resolved next program counter |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Return address to link |

## Verification
Equality branches are driven with equal and unequal operand pairs so that taken and not-taken targets can be told apart. The zero-equals-zero case confirms the unconditional form. Sign tests run every compare code against a negative, a zero and a positive operand, which separates strict from non-strict compares and exposes an unsigned compare. Extreme displacements and a PC near a region boundary catch truncated sign extension, a missing shift, and a region taken from the current rather than the following instruction. Calls with zero and non-zero link destinations check the default link index.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [2:0] {
        XFER_SEQ     = 3'd0,
        XFER_BEQ     = 3'd1,
        XFER_BNE     = 3'd2,
        XFER_BZC     = 3'd3,
        XFER_JMP     = 3'd4,
        XFER_CALL    = 3'd5,
        XFER_JREG    = 3'd6,
        XFER_CALLREG = 3'd7
    } xfer_kind_e;

    localparam int ZC_W = 5;

    localparam logic [ZC_W-1:0] ZC_LTZ = 5'd0;
    localparam logic [ZC_W-1:0] ZC_GEZ = 5'd1;
    localparam logic [ZC_W-1:0] ZC_LEZ = 5'd2;
    localparam logic [ZC_W-1:0] ZC_GTZ = 5'd3;

endpackage

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_kind_e        kind,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [ZC_W-1:0]   zsel,
    output logic              cond_hit
);

    logic a_neg;
    logic a_zero;
    logic ops_eq;
    logic zc_hit;

    assign a_neg  = opa[XLEN-1];
    assign a_zero = (opa == '0);
    assign ops_eq = (opa == opb);

    always_comb begin
        unique case (zsel)
            ZC_LTZ:  zc_hit = a_neg;
            ZC_GEZ:  zc_hit = ~a_neg;
            ZC_LEZ:  zc_hit = a_neg | a_zero;
            ZC_GTZ:  zc_hit = ~a_neg & ~a_zero;
            default: zc_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (kind)
            XFER_BEQ: cond_hit = ops_eq;
            XFER_BNE: cond_hit = ~ops_eq;
            XFER_BZC: cond_hit = zc_hit;
            default:  cond_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [JF_W-1:0]  jfield,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  jmp_pc
);

    localparam int INSN_B   = 4;
    localparam int SHIFT    = 2;
    localparam int EXT_W    = XLEN - OFF_W - SHIFT;
    localparam int REGION_W = XLEN - JF_W - SHIFT;

    logic [XLEN-1:0] byte_disp;

    assign seq_pc    = pc + XLEN'(INSN_B);
    assign byte_disp = {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
    assign br_pc     = seq_pc + byte_disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_pc = {seq_pc[XLEN-1 -: REGION_W], jfield, {SHIFT{1'b0}}};
        end else begin : g_flat
            assign jmp_pc = {jfield[XLEN-SHIFT-1:0], {SHIFT{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/bru_link.sv
module bru_link
    import bru_pkg::*;
#(
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  xfer_kind_e        kind,
    input  logic [RIDX_W-1:0] dst,
    output logic              we,
    output logic [RIDX_W-1:0] idx
);

    localparam logic [RIDX_W-1:0] DEF_IDX = RIDX_W'(LINK_REG);

    always_comb begin
        unique case (kind)
            XFER_CALL: begin
                we  = 1'b1;
                idx = DEF_IDX;
            end
            XFER_CALLREG: begin
                we  = 1'b1;
                idx = (dst == '0) ? DEF_IDX : dst;
            end
            default: begin
                we  = 1'b0;
                idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/bru_nextpc.sv
module bru_nextpc
    import bru_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          OFF_W    = 16,
    parameter int          JF_W     = 26,
    parameter int          RIDX_W   = 5,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [2:0]        xfer_kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [ZC_W-1:0]   zcond,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JF_W-1:0]   jmp_field,
    input  logic [RIDX_W-1:0] link_dst,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val
);

    xfer_kind_e        kind;
    logic              cond_hit;
    logic [XLEN-1:0]   seq_pc;
    logic [XLEN-1:0]   br_pc;
    logic [XLEN-1:0]   jmp_pc;
    logic              lk_we;
    logic [RIDX_W-1:0] lk_idx;
    logic [XLEN-1:0]   pc_d;
    logic              tk_d;
    logic              primed;

    assign kind = xfer_kind_e'(xfer_kind);

    bru_cond #(.XLEN(XLEN)) u_cond (
        .kind     (kind),
        .opa      (opnd_a),
        .opb      (opnd_b),
        .zsel     (zcond),
        .cond_hit (cond_hit)
    );

    bru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
        .pc     (cur_pc),
        .off    (br_off),
        .jfield (jmp_field),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    bru_link #(.RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
        .kind (kind),
        .dst  (link_dst),
        .we   (lk_we),
        .idx  (lk_idx)
    );

    always_comb begin
        unique case (kind)
            XFER_BEQ, XFER_BNE, XFER_BZC: begin
                tk_d = cond_hit;
                pc_d = cond_hit ? br_pc : seq_pc;
            end
            XFER_JMP, XFER_CALL: begin
                tk_d = 1'b1;
                pc_d = jmp_pc;
            end
            XFER_JREG, XFER_CALLREG: begin
                tk_d = 1'b1;
                pc_d = opnd_a;
            end
            default: begin
                tk_d = 1'b0;
                pc_d = seq_pc;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc  <= XLEN'(RESET_PC);
            taken    <= 1'b0;
            link_we  <= 1'b0;
            link_idx <= '0;
            link_val <= '0;
            primed   <= 1'b0;
        end else begin
            next_pc  <= pc_d;
            taken    <= tk_d;
            link_we  <= lk_we;
            link_idx <= lk_idx;
            link_val <= seq_pc;
            primed   <= 1'b1;
        end
    end

    AST_SEQ_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd0) |-> (next_pc == $past(cur_pc) + XLEN'(4) && !taken)); // R2

    AST_JREG_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd6) |-> (next_pc == $past(opnd_a) && taken)); // R9

    AST_JMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd4) |->
        (next_pc[XLEN-1 -: 4] == $past(cur_pc + XLEN'(4)) >> (XLEN-4) && next_pc[1:0] == 2'b00)); // R8

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd5) |->
        (link_we && link_idx == RIDX_W'(LINK_REG) && link_val == $past(cur_pc) + XLEN'(4))); // R10

    AST_NO_STRAY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) != 3'd5 && $past(xfer_kind) != 3'd7) |-> !link_we); // R12

    AST_CALLREG_IDX_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd7) |-> (link_we && link_idx != '0)); // R11

    AST_ZERO_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(xfer_kind) == 3'd1 && $past(opnd_a) == '0 && $past(opnd_b) == '0) |-> taken); // R7

endmodule

// File: tb/bru_nextpc_tb.sv
module bru_nextpc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [2:0]  xfer_kind = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  zcond = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [4:0]  link_dst = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bru_nextpc u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .xfer_kind(xfer_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .zcond(zcond), .br_off(br_off),
        .jmp_field(jmp_field), .link_dst(link_dst), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] br_tgt(input logic [31:0] pc, input logic [15:0] off);
        return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    task automatic apply(input logic [2:0] k, input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] zc, input logic [15:0] off,
                         input logic [25:0] jf, input logic [4:0] ld);
        xfer_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b;
        zcond = zc; br_off = off; jmp_field = jf; link_dst = ld;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 next_pc", next_pc, 32'hBFC0_0000);
        chk("R1 taken", {31'd0, taken}, 32'd0);
        chk("R1 link_we", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_seq();
        apply(3'd0, 32'h0040_0020, 32'd1, 32'd1, 5'd0, 16'h0010, 26'h3FF, 5'd3);
        chk("R2 next_pc", next_pc, 32'h0040_0024);
        chk("R2 taken", {31'd0, taken}, 32'd0);
        chk("R12 seq no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_eq_ne();
        apply(3'd1, 32'h0040_0044, 32'd5, 32'd5, 5'd0, 16'hFFF9, '0, '0);
        chk("R3 beq taken pc", next_pc, 32'h0040_002C);
        chk("R3 beq taken", {31'd0, taken}, 32'd1);
        chk("R12 beq no link", {31'd0, link_we}, 32'd0);
        apply(3'd1, 32'h0040_0044, 32'd5, 32'd6, 5'd0, 16'hFFF9, '0, '0);
        chk("R3 beq fall pc", next_pc, 32'h0040_0048);
        chk("R3 beq fall", {31'd0, taken}, 32'd0);
        apply(3'd2, 32'h0040_0044, 32'd5, 32'd6, 5'd0, 16'h0003, '0, '0);
        chk("R3 bne taken pc", next_pc, 32'h0040_0054);
        chk("R3 bne taken", {31'd0, taken}, 32'd1);
        apply(3'd2, 32'h0040_0044, 32'h8000_0000, 32'h8000_0000, 5'd0, 16'h0003, '0, '0);
        chk("R3 bne fall pc", next_pc, 32'h0040_0048);
    endtask

    task automatic t_zero_zero();
        apply(3'd1, 32'h0000_1000, 32'd0, 32'd0, 5'd0, 16'h0100, '0, '0);
        chk("R7 zero eq zero pc", next_pc, br_tgt(32'h0000_1000, 16'h0100));
        chk("R7 zero eq zero taken", {31'd0, taken}, 32'd1);
    endtask

    task automatic t_sign();
        logic [31:0] vals [3];
        vals[0] = 32'hFFFF_FFFF; vals[1] = 32'd0; vals[2] = 32'd1;
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 3; v++) begin
                logic neg, zer, exp_t;
                neg = vals[v][31];
                zer = (vals[v] == 32'd0);
                case (c)
                    0: exp_t = neg;
                    1: exp_t = !neg;
                    2: exp_t = neg || zer;
                    default: exp_t = !neg && !zer;
                endcase
                apply(3'd3, 32'h0000_2000, vals[v], 32'h7FFF_FFFF, 5'(c), 16'h0020, '0, '0);
                chk($sformatf("R4 code %0d val %0d taken", c, v), {31'd0, taken}, {31'd0, exp_t});
                chk($sformatf("R4 code %0d val %0d pc", c, v), next_pc,
                    exp_t ? br_tgt(32'h0000_2000, 16'h0020) : 32'h0000_2004);
            end
        end
        apply(3'd3, 32'h0000_2000, 32'h8000_0000, 32'd0, 5'd0, 16'h0020, '0, '0);
        chk("R4 most negative ltz", {31'd0, taken}, 32'd1);
        chk("R12 sign test no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_badcond();
        apply(3'd3, 32'h0000_3000, 32'hFFFF_FFFF, 32'd0, 5'd4, 16'h0020, '0, '0);
        chk("R5 code 4 pc", next_pc, 32'h0000_3004);
        chk("R5 code 4 taken", {31'd0, taken}, 32'd0);
        apply(3'd3, 32'h0000_3000, 32'd7, 32'd0, 5'd31, 16'h0020, '0, '0);
        chk("R5 code 31 pc", next_pc, 32'h0000_3004);
    endtask

    task automatic t_reach();
        apply(3'd1, 32'h0000_0000, 32'd9, 32'd9, 5'd0, 16'h7FFF, '0, '0);
        chk("R6 max fwd", next_pc, 32'h0002_0000);
        apply(3'd1, 32'h0010_0000, 32'd9, 32'd9, 5'd0, 16'h8000, '0, '0);
        chk("R6 max back", next_pc, 32'h000E_0004);
        apply(3'd2, 32'h0000_0010, 32'd1, 32'd2, 5'd0, 16'hFFF0, '0, '0);
        chk("R6 wrap", next_pc, 32'hFFFF_FFD4);
    endtask

    task automatic t_jump();
        apply(3'd4, 32'h3FFF_FFFC, 32'd0, 32'd0, 5'd0, '0, 26'h3FF_FFFF, 5'd0);
        chk("R8 region next", next_pc, 32'h4FFF_FFFC);
        chk("R8 taken", {31'd0, taken}, 32'd1);
        chk("R12 jump no link", {31'd0, link_we}, 32'd0);
        apply(3'd4, 32'hA000_0000, 32'd0, 32'd0, 5'd0, '0, 26'h010_0008, 5'd0);
        chk("R8 field", next_pc, 32'hA040_0020);
    endtask

    task automatic t_jreg();
        apply(3'd6, 32'h0000_4000, 32'h1234_5678, 32'd0, 5'd0, '0, '0, 5'd7);
        chk("R9 next", next_pc, 32'h1234_5678);
        chk("R9 taken", {31'd0, taken}, 32'd1);
        chk("R12 jreg no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_call();
        apply(3'd5, 32'h0040_0100, 32'hDEAD_0000, 32'd0, 5'd0, '0, 26'h010_0040, 5'd4);
        chk("R10 next", next_pc, 32'h0040_0100);
        chk("R10 we", {31'd0, link_we}, 32'd1);
        chk("R10 idx", {27'd0, link_idx}, 32'd31);
        chk("R10 val", link_val, 32'h0040_0104);
    endtask

    task automatic t_callreg();
        apply(3'd7, 32'h0000_5000, 32'h0080_0000, 32'd0, 5'd0, '0, '0, 5'd0);
        chk("R11 next", next_pc, 32'h0080_0000);
        chk("R11 default idx", {27'd0, link_idx}, 32'd31);
        chk("R11 we", {31'd0, link_we}, 32'd1);
        chk("R11 val", link_val, 32'h0000_5004);
        apply(3'd7, 32'h0000_6000, 32'h0090_0000, 32'd0, 5'd0, '0, '0, 5'd9);
        chk("R11 chosen idx", {27'd0, link_idx}, 32'd9);
        chk("R11 chosen val", link_val, 32'h0000_6004);
    endtask

    task automatic t_latency();
        apply(3'd0, 32'h0000_1000, '0, '0, '0, '0, '0, '0);
        cur_pc = 32'h0000_2000;
        #2;
        chk("R13 held before edge", next_pc, 32'h0000_1004);
        @(posedge clk);
        #1;
        chk("R13 updated after edge", next_pc, 32'h0000_2004);
    endtask

    initial begin
        #20;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_seq();
        t_eq_ne();
        t_zero_zero();
        t_sign();
        t_badcond();
        t_reach();
        t_jump();
        t_jreg();
        t_call();
        t_callreg();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule